// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for nine-bit words that sits between two clock domains. Words enter on the write clock and leave on the read clock. The two clocks may be one shared net or two unrelated free-running clocks, and a read and a write may happen at the same edge. Each port is qualified by a pair of enables. The second write enable has a second job: when it is low while the first write enable is asserted, the write clock loads the two threshold offsets from the data input and stores no data.

Status goes back to both sides. Empty and almost-empty are generated in the read domain. Full and almost-full are generated in the write domain. Each side sees the other side's pointer through a Gray-coded two-stage synchronizer, so a flag can stay asserted a few cycles longer than the true fill level requires, but it never clears early. The read data is registered and reaches the output pins only while the output enable is asserted. The depth is a parameter and has a small default.

Top module: `dcf_top`

## Requirements
- R1: A word from `din` is stored at a rising `wr_clk` edge when `wr_en_n` is 0, `wr_ld` is 1 and `full` is 0. Holding those levels stores one word on every edge.
- R2: A rising `rd_clk` edge with `rd_en_n` and `rd_en2_n` both 0 and `empty` 0 removes the oldest word and registers it as the read data. The word is visible on `dout` after that edge. If either read enable is 1, nothing is removed and the read data holds.
- R3: A write attempted while `full` is 1 is ignored. The stored words and their order are unchanged.
- R4: A read attempted while `empty` is 1 is ignored. The read data holds its value and no pointer moves.
- R5: `empty` is 1 after reset. It rises at the same read edge that removes the last word. It falls within three read-clock edges after a write becomes visible.
- R6: `full` rises at the same write edge that stores the word making the fill level equal DEPTH. It falls within three write-clock edges after a read.
- R7: Once the pointers have settled, `almost_empty` is 1 exactly when the fill level is at most the almost-empty offset.
- R8: Once the pointers have settled, `almost_full` is 1 exactly when the fill level is at least DEPTH minus the almost-full offset.
- R9: Both offsets reset to DEPTH/8. A rising `wr_clk` edge with `wr_en_n` 0 and `wr_ld` 0 takes `din[log2(DEPTH)-1:0]` as an offset and stores no data. The first such edge after reset writes the almost-empty offset, the next writes the almost-full offset, and the two keep alternating in that order.
- R10: `dout` is high-impedance while `oe_n` is 1 and carries the read data while `oe_n` is 0.
- R11: A read and a write at the same edge on a partly filled buffer leave the fill level unchanged and keep first-in first-out order.
- R12: With `wr_clk` and `rd_clk` unrelated, every word is delivered once, in order and uncorrupted. Each pointer's Gray code changes in at most one bit per edge of its own clock.
- R13: Asserting `rst_n` (active low) empties the buffer and clears the read data to 0, whatever the buffer held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_n | input | 1 | First write enable, active low |
| wr_ld | input | 1 | Second write enable: 1 stores data, 0 loads an offset |
| din | input | 9 | Write data, also the offset value while loading |
| rd_en_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable for `dout`, active low |
| dout | output | 9 | Registered read data, three-stated |
| empty | output | 1 | No word available to read |
| full | output | 1 | No room for another word |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset |
| almost_full | output | 1 | Fill level at or above DEPTH minus the almost-full offset |

## Verification
The two functions that can fall in the same cycle are a read and a write at one shared edge. The bench provokes this by holding both ports' enables for several consecutive edges while the buffer sits at a middle level, with a new word on `din` at each edge. The result is judged word by word against an in-order queue model. The fill level must stay constant and the queue must drain in order afterwards. The same pairing is also exercised at the boundaries: writes pressed against a full buffer, reads pressed against an empty one, and a full sweep of fill levels with both the reset offsets and loaded offsets.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int DATA_W      = 9;
    localparam int SYNC_STAGES = 2;

    // Which offset register the next load edge writes
    typedef enum logic {
        OFS_AE = 1'b0,
        OFS_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign st_d[s] = d;
            end else begin : g_next
                assign st_d[s] = st_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[s] <= '0;
                else        st_q[s] <= st_d[s];
            end
        end
    endgenerate

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          wr_ld,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          almost_full,
    output logic [AW-1:0] ae_ofs
);
    localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] OFS_RST = AW'(DEPTH / 8);

    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic          full;
        logic          afull;
        logic [AW-1:0] ae_ofs;
        logic [AW-1:0] af_ofs;
        ofs_sel_e      sel;
    } wst_t;

    wst_t        st_d, st_q;
    logic        wr_try, ld, we;
    logic [AW:0] bin_nx, rbin, lvl;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d   = st_q;
        wr_try = !wr_en_n && wr_ld;
        ld     = !wr_en_n && !wr_ld;
        we     = wr_try && !st_q.full;
        bin_nx = st_q.bin + {{AW{1'b0}}, we};
        st_d.bin  = bin_nx;
        st_d.gray = bin_nx ^ (bin_nx >> 1);
        if (ld) begin
            if (st_q.sel == OFS_AE) begin
                st_d.ae_ofs = ofs_in;
                st_d.sel    = OFS_AF;
            end else begin
                st_d.af_ofs = ofs_in;
                st_d.sel    = OFS_AE;
            end
        end
        rbin       = g2b(rgray_s);
        lvl        = bin_nx - rbin;
        st_d.full  = (st_d.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        st_d.afull = (lvl >= (DEPTH_W - {1'b0, st_d.af_ofs}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ae_ofs <= OFS_RST;
            st_q.af_ofs <= OFS_RST;
            st_q.sel    <= OFS_AE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we      = we;
    assign mem_waddr   = st_q.bin[AW-1:0];
    assign wgray       = st_q.gray;
    assign full        = st_q.full;
    assign almost_full = st_q.afull;
    assign ae_ofs      = st_q.ae_ofs;

    // R3: a write pressed against full moves no pointer
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !wr_en_n && wr_ld) |=> $stable(st_q.bin));

    // R8: write-side view of the fill level never exceeds the depth
    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.bin - g2b(rgray_s)) <= DEPTH_W));

    // R9: the first offset of a load pair lands in the almost-empty register
    p_load_ae_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !wr_ld && st_q.sel == OFS_AE) |=> (st_q.ae_ofs == $past(ofs_in)));

    // R12: write pointer Gray code moves by at most one bit per edge
    p_gray_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          rd_en2_n,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          almost_empty
);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        empty;
        logic        aempty;
    } rst_t;

    rst_t        st_d, st_q;
    logic        re;
    logic [AW:0] bin_nx, wbin, lvl;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d        = st_q;
        re          = !rd_en_n && !rd_en2_n && !st_q.empty;
        bin_nx      = st_q.bin + {{AW{1'b0}}, re};
        st_d.bin    = bin_nx;
        st_d.gray   = bin_nx ^ (bin_nx >> 1);
        wbin        = g2b(wgray_s);
        lvl         = wbin - bin_nx;
        st_d.empty  = (st_d.gray == wgray_s);
        st_d.aempty = (lvl <= {1'b0, ae_ofs});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_re       = re;
    assign mem_raddr    = st_q.bin[AW-1:0];
    assign rgray        = st_q.gray;
    assign empty        = st_q.empty;
    assign almost_empty = st_q.aempty;

    // R4: a read pressed against empty moves no pointer
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.empty && !rd_en_n && !rd_en2_n) |=> $stable(st_q.bin));

    // R7: read-side view of the fill level stays within the depth
    p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((g2b(wgray_s) - st_q.bin) <= DEPTH_W));

    // R12: read pointer Gray code moves by at most one bit per edge
    p_gray_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_q.gray ^ $past(st_q.gray)) <= 1));
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem[raddr];
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcf_top.sv
module dcf_top
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_ld,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    output wire  [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic              mem_we, mem_re;
    logic [AW-1:0]     waddr, raddr, ae_ofs;
    logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] rdata;

    dcf_wr #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_ld(wr_ld),
        .ofs_in(din[AW-1:0]), .rgray_s(rgray_s), .mem_we(mem_we),
        .mem_waddr(waddr), .wgray(wgray), .full(full),
        .almost_full(almost_full), .ae_ofs(ae_ofs)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_rd #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .mem_re(mem_re),
        .mem_raddr(raddr), .rgray(rgray), .empty(empty),
        .almost_empty(almost_empty)
    );

    dcf_mem #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(din),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(mem_re), .raddr(raddr),
        .rdata(rdata)
    );

    assign dout = oe_n ? {DATA_W{1'bz}} : rdata;

    // R4: read data holds while a read is refused for lack of words
    p_hold_on_empty_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && !rd_en_n && !rd_en2_n) |=> $stable(rdata));
endmodule

// File: tb/sim_dcf_top.sv
`timescale 1ns/1ps
module sim_dcf_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0, clk_b = 1'b0, async_mode = 1'b0;
    logic       rst_n = 1'b0, wr_en_n = 1'b1, wr_ld = 1'b1;
    logic       rd_en_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
    logic [8:0] din = '0;
    wire  [8:0] dout;
    logic       empty, full, almost_empty, almost_full;
    logic       rd_clk;

    int n_chk = 0, n_bad = 0;
    int mq[$];
    int last_word = 0;

    always #2.5 clk = ~clk;
    always #3.5 clk_b = ~clk_b;
    assign rd_clk = async_mode ? clk_b : clk;

    dcf_top #(.DEPTH(DEPTH)) u0 (
        .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_ld(wr_ld), .din(din), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
        .oe_n(oe_n), .dout(dout), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en_n = 1'b1; wr_ld = 1'b1; rd_en_n = 1'b1; rd_en2_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic push(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en_n = 1'b0; wr_ld = 1'b1; din = 9'(base + i * 11);
            if (mq.size() < DEPTH) mq.push_back(int'(din));
        end
        @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    task automatic pop(input int n, input string req);
        if (n > 0) begin
            @(negedge rd_clk);
            rd_en_n = 1'b0; rd_en2_n = 1'b0;
            for (int i = 0; i < n; i++) begin
                int e;
                @(negedge rd_clk);
                e = mq.pop_front();
                chk(dout === 9'(e), req, int'(dout), e);
                last_word = e;
                if (i == n - 1) begin rd_en_n = 1'b1; rd_en2_n = 1'b1; end
            end
        end
    endtask

    task automatic load_ofs(input int ae, input int af);
        @(negedge clk); wr_en_n = 1'b0; wr_ld = 1'b0; din = 9'(ae);
        @(negedge clk); din = 9'(af);
        @(negedge clk); wr_en_n = 1'b1; wr_ld = 1'b1;
    endtask

    task automatic chk_flags(input int n, input int ae, input int af);
        chk(empty == (n == 0), "R5 empty level", int'(empty), int'(n == 0));
        chk(full == (n == DEPTH), "R6 full level", int'(full), int'(n == DEPTH));
        chk(almost_empty == (n <= ae), "R7 almost_empty", int'(almost_empty), int'(n <= ae));
        chk(almost_full == (n >= DEPTH - af), "R8 almost_full", int'(almost_full),
            int'(n >= DEPTH - af));
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R13: reset state
        chk(empty && !full && almost_empty && !almost_full, "R13 reset flags",
            int'({empty, full, almost_empty, almost_full}), 4'b1010);
        chk(dout === 9'd0, "R13 reset data", int'(dout), 0);

        // R1 R2 R5..R9: sweep every fill level with reset offsets, then loaded ones
        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int n = 0; n <= DEPTH; n++) begin
                int ae = (cfg == 0) ? DEPTH / 8 : 5;
                int af = (cfg == 0) ? DEPTH / 8 : 3;
                do_reset();
                if (cfg == 1) begin
                    load_ofs(ae, af);
                    settle();
                    chk(empty == 1'b1, "R9 load stores no data", int'(empty), 1);
                end
                push(n, n * 37);
                settle();
                chk_flags(n, ae, af);
                pop(n, "R2 sweep order");
                settle();
                chk(empty == 1'b1, "R5 drained", int'(empty), 1);
            end
        end

        // R6: full rises on the edge storing the last word; R5: empty on last read
        do_reset();
        push(DEPTH - 1, 3);
        settle();
        chk(full == 1'b0, "R6 one short", int'(full), 0);
        @(negedge clk); wr_en_n = 1'b0; din = 9'h1AA; mq.push_back(9'h1AA);
        @(negedge clk); wr_en_n = 1'b1;
        chk(full == 1'b1, "R6 full same edge", int'(full), 1);
        pop(DEPTH - 1, "R2 before last");
        settle();
        @(negedge clk); rd_en_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge clk); rd_en_n = 1'b1; rd_en2_n = 1'b1;
        chk(dout === 9'h1AA, "R2 last word", int'(dout), 9'h1AA);
        chk(empty == 1'b1, "R5 empty same edge", int'(empty), 1);

        // R3: overflow is ignored
        do_reset();
        push(DEPTH + 4, 100);
        settle();
        chk(full == 1'b1, "R3 full after overflow", int'(full), 1);
        pop(DEPTH, "R3 overflow kept order");
        settle();
        chk(empty == 1'b1, "R3 nothing extra", int'(empty), 1);

        // R4: underflow is ignored, read data holds, pointer unmoved
        @(negedge clk); rd_en_n = 1'b0; rd_en2_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dout === 9'(last_word), "R4 hold on empty", int'(dout), last_word);
        end
        rd_en_n = 1'b1; rd_en2_n = 1'b1;
        push(1, 9'h055);
        settle();
        pop(1, "R4 pointer unmoved");

        // R2: a single read enable is not enough
        push(2, 200);
        settle();
        @(negedge clk); rd_en_n = 1'b0; rd_en2_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_en_n = 1'b1; rd_en2_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_en2_n = 1'b1;
        chk(dout === 9'(last_word), "R2 half enable holds", int'(dout), last_word);
        pop(2, "R2 half enable no removal");

        // R10: output enable
        oe_n = 1'b1;
        @(negedge clk);
        chk(dout === 9'bz, "R10 high impedance", int'(dout === 9'bz), 1);
        oe_n = 1'b0;
        @(negedge clk);
        chk(dout === 9'(last_word), "R10 driven", int'(dout), last_word);

        // R11: read and write at the same edge
        do_reset();
        push(5, 300);
        settle();
        @(negedge clk);
        wr_en_n = 1'b0; wr_ld = 1'b1; rd_en_n = 1'b0; rd_en2_n = 1'b0; din = 9'd400;
        for (int i = 0; i < 8; i++) begin
            int e;
            @(negedge clk);
            e = mq.pop_front();
            mq.push_back(int'(din));
            chk(dout === 9'(e), "R11 simultaneous order", int'(dout), e);
            din = 9'(401 + i);
        end
        wr_en_n = 1'b1; rd_en_n = 1'b1; rd_en2_n = 1'b1;
        settle();
        chk_flags(5, DEPTH / 8, DEPTH / 8);
        pop(5, "R11 level kept");

        // R13: reset discards contents
        push(6, 50);
        settle();
        do_reset();
        settle();
        chk(empty && almost_empty && !full, "R13 reset discards", int'(empty), 1);
        chk(dout === 9'd0, "R13 data cleared", int'(dout), 0);

        // R12: independent clocks
        rst_n = 1'b0;
        async_mode = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        repeat (4) @(negedge clk);
        push(10, 77);
        settle();
        chk(empty == 1'b0, "R12 words crossed", int'(empty), 0);
        pop(10, "R12 async order");
        settle();
        chk(empty == 1'b1 && full == 1'b0, "R12 async drained", int'(empty), 1);
        push(DEPTH, 9);
        settle();
        chk(full == 1'b1, "R12 async full", int'(full), 1);
        pop(DEPTH, "R12 async full drain");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule